// File: doc/BRIEF.md
# Dual Firmware Image Boot Verifier

This block runs while the processor is still in reset. It reads a primary firmware image from a byte-wide ROM port, one byte per clock, and checks its integrity. If that check fails, it switches the ROM bank to a secondary image and checks that image the same way. When an image passes, the block releases the processor reset, and a bank-select output names the image that passed. When both images fail, the block enters a terminal halt and the processor stays in reset until the next system reset. The processor's reset vector sits near the top of the firmware window, so an image is trusted only after every byte of it has been checked.

The check method is a strap input. In the additive method, an image is good when its bytes sum to zero. In the CRC method, a CRC-32 over the image body is compared against a trailer stored in the image. A second strap turns on shadowing. With shadowing on, the chosen image is copied into RAM before release, so the processor can then run from the faster memory. Image length is a parameter, 64 KiB by default. A sticky three-bit status records what the boot sequence did, and it stays readable after release.

Top module: `dual_image_boot_verifier`

## Requirements
- R1: While `rst_n` is low, `cpu_rst_n`, `bank_sel`, `ram_we`, `boot_status` and `rom_addr` are all zero.
- R2: After reset, the primary image is read at `rom_addr` = {bank bit 0, offset}, with offsets 0 through IMG_BYTES-1 on consecutive cycles, one offset per cycle. The bank bit is the MSB of `rom_addr`, and `rom_data` is sampled in the same cycle as its address.
- R3: With `use_crc` = 0, an image passes exactly when the 8-bit modulo-256 sum of all its bytes is zero.
- R4: With `use_crc` = 1, an image passes exactly when its last four bytes equal the CRC of all the preceding bytes. The last four bytes are read as a big-endian number, so the first of them is the most significant byte. The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, processes each byte MSB first, and has no reflection and no final XOR.
- R5: If the primary passes and shadowing is off, `cpu_rst_n` goes high in the cycle after the last primary byte is read. At that point `bank_sel` is 0 and `boot_status` is 3'b001.
- R6: If the primary fails, `bank_sel` becomes 1 in the cycle after its last byte and status bit 1 sets. The secondary image is then read over offsets 0 through IMG_BYTES-1 in the same way.
- R7: If the secondary also fails, status bit 2 sets in the cycle after its last byte. From then on, `cpu_rst_n` stays low and `ram_we` stays low until reset.
- R8: With `shadow_en` = 1, a passing image is copied before release: one byte per cycle, with `ram_we` high, `ram_addr` equal to the ROM offset and `ram_wdata` equal to that ROM byte. Release comes in the cycle after the final write.
- R9: Once set, `bank_sel` and every status bit stay set until reset. The status bit encoding is: bit 0 means the primary passed, bit 1 means the secondary was used, bit 2 means halted.
- R10: Once `cpu_rst_n` is high it stays high until reset, and it is never high in a cycle where `ram_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_crc | input | 1 | Strap: 0 selects the additive check, 1 selects the CRC check |
| shadow_en | input | 1 | Strap: copy the chosen image into RAM before release |
| rom_addr | output | AW+1 | ROM read address: the MSB is the bank, the lower AW bits are the offset |
| rom_data | input | 8 | ROM read data for the current `rom_addr` |
| ram_we | output | 1 | RAM write strobe used during shadow copy |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| cpu_rst_n | output | 1 | Processor reset, active low; high means released |
| bank_sel | output | 1 | Image the processor boots from (0 primary, 1 secondary) |
| boot_status | output | 3 | Sticky status {halted, secondary_used, primary_ok} |

## Verification
The bound checker watches several rules on every cycle:
- the bank and status bits never clear once set;
- release is permanent, and release and RAM writes never overlap;
- a halted block never releases;
- shadow writes walk the RAM addresses in order, in step with the ROM offset of the selected bank.

Whether each image actually passes or fails depends on the arithmetic over its contents. Only the bench's scenarios can show that: they build good and corrupted images for both check methods, with and without shadowing, compare every cycle against a behavioural model, and read back the RAM copy.

// File: rtl/bootver_pkg.sv
// Package: shared phase encoding, status layout and CRC step for the boot verifier.
// Assumes: bytes enter the CRC MSB first, no reflection.
package bootver_pkg;

    typedef enum logic [2:0] {
        PH_PRIMARY   = 3'd0,
        PH_SECONDARY = 3'd1,
        PH_SHADOW    = 3'd2,
        PH_RUN       = 3'd3,
        PH_HALT      = 3'd4
    } phase_e;

    typedef struct packed {
        logic halted;
        logic secondary_used;
        logic primary_ok;
    } status_t;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance a CRC-32 register by one byte, MSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in, input logic [7:0] b);
        logic [31:0] c;
        c = crc_in ^ {b, 24'h0};
        for (int k = 0; k < 8; k++) begin
            c = c[31] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/bootver_walker.sv
// Byte walker: offset counter that sweeps 0..IMG_BYTES-1 for a scan or a copy.
// Assumes: restart has priority over advance; the counter holds when idle.
module bootver_walker #(
    parameter int IMG_BYTES = 65536,
    localparam int AW = $clog2(IMG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          restart,
    output logic [AW-1:0] idx,
    output logic          last
);

    localparam logic [AW-1:0] LAST_IDX = AW'(IMG_BYTES - 1);

    // Flag the final offset of the image.
    assign last = (idx == LAST_IDX);

    // Step the offset, or return it to zero at the end of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/bootver_integrity.sv
// Integrity unit: accumulates the additive sum and, when built in, the CRC over one image.
// pass_o is valid in the cycle where the last byte is presented on byte_i.
// Assumes: IMG_BYTES >= 5 so the CRC trailer leaves a non-empty body.
module bootver_integrity
    import bootver_pkg::*;
#(
    parameter int IMG_BYTES   = 65536,
    parameter bit CRC_SUPPORT = 1'b1,
    localparam int AW = $clog2(IMG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_crc,
    input  logic          en,
    input  logic          clear,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    byte_i,
    output logic          pass_o
);

    localparam logic [AW-1:0] TAIL_START = AW'(IMG_BYTES - 4);

    logic [7:0] sum_q;
    logic [7:0] sum_next;
    logic       sum_pass;

    // Additive check: the sum including the current byte must be zero.
    assign sum_next = sum_q + byte_i;
    assign sum_pass = (sum_next == 8'h00);

    // Running byte sum, cleared between images.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_q <= '0;
        end else if (en) begin
            sum_q <= sum_next;
        end
    end

    generate
        if (CRC_SUPPORT) begin : g_crc
            logic [31:0] crc_q;
            logic [31:0] tail_q;
            logic [31:0] tail_next;
            logic        in_tail;

            assign in_tail   = (idx >= TAIL_START);
            assign tail_next = {tail_q[23:0], byte_i};

            // Body bytes feed the CRC; the last four bytes build the stored trailer.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    crc_q  <= CRC_SEED;
                    tail_q <= '0;
                end else if (en) begin
                    if (in_tail) begin
                        tail_q <= tail_next;
                    end else begin
                        crc_q <= crc_step(crc_q, byte_i);
                    end
                end
            end

            // Pick the verdict for the selected method.
            assign pass_o = use_crc ? (tail_next == crc_q) : sum_pass;
        end else begin : g_sum_only
            // Without the CRC datapath only the additive verdict exists.
            assign pass_o = sum_pass;
        end
    endgenerate

endmodule

// File: rtl/bootver_sequencer.sv
// Sequencer: primary check, fallback to secondary, optional shadow copy, release or halt.
// Assumes: last and pass come from the walker and integrity unit for the current cycle.
module bootver_sequencer
    import bootver_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    shadow_en,
    input  logic    last,
    input  logic    pass,
    output phase_e  phase,
    output logic    bank_sel,
    output status_t status,
    output logic    active,
    output logic    scan_en,
    output logic    restart
);

    phase_e phase_next;

    // Phases that consume one ROM byte per cycle.
    assign active  = (phase == PH_PRIMARY) || (phase == PH_SECONDARY) || (phase == PH_SHADOW);
    assign scan_en = (phase == PH_PRIMARY) || (phase == PH_SECONDARY);
    assign restart = active && last;

    // Choose the next phase at the end of each pass.
    always_comb begin
        phase_next = phase;
        if (last) begin
            unique case (phase)
                PH_PRIMARY:   phase_next = pass ? (shadow_en ? PH_SHADOW : PH_RUN) : PH_SECONDARY;
                PH_SECONDARY: phase_next = pass ? (shadow_en ? PH_SHADOW : PH_RUN) : PH_HALT;
                PH_SHADOW:    phase_next = PH_RUN;
                default:      phase_next = phase;
            endcase
        end
    end

    // Phase register with sticky bank and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_PRIMARY;
            bank_sel <= 1'b0;
            status   <= '0;
        end else begin
            phase <= phase_next;
            if (last && phase == PH_PRIMARY) begin
                if (pass) begin
                    status.primary_ok <= 1'b1;
                end else begin
                    bank_sel              <= 1'b1;
                    status.secondary_used <= 1'b1;
                end
            end
            if (last && phase == PH_SECONDARY && !pass) begin
                status.halted <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_image_boot_verifier.sv
// Top: verifies a primary then a secondary firmware image over a byte ROM port,
// optionally shadows the winner into RAM, then releases the CPU reset or halts.
// Assumes: ROM data is combinational in rom_addr; straps are static while running.
module dual_image_boot_verifier
    import bootver_pkg::*;
#(
    parameter int IMG_BYTES   = 65536,
    parameter bit CRC_SUPPORT = 1'b1,
    localparam int AW = $clog2(IMG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_crc,
    input  logic          shadow_en,
    output logic [AW:0]   rom_addr,
    input  logic [7:0]    rom_data,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          cpu_rst_n,
    output logic          bank_sel,
    output logic [2:0]    boot_status
);

    phase_e        phase;
    status_t       status;
    logic          active;
    logic          scan_en;
    logic          restart;
    logic          last;
    logic          pass;
    logic [AW-1:0] idx;

    bootver_walker #(.IMG_BYTES(IMG_BYTES)) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (active),
        .restart (restart),
        .idx     (idx),
        .last    (last)
    );

    bootver_integrity #(.IMG_BYTES(IMG_BYTES), .CRC_SUPPORT(CRC_SUPPORT)) u_integrity (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_crc (use_crc),
        .en      (scan_en),
        .clear   (restart),
        .idx     (idx),
        .byte_i  (rom_data),
        .pass_o  (pass)
    );

    bootver_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow_en (shadow_en),
        .last      (last),
        .pass      (pass),
        .phase     (phase),
        .bank_sel  (bank_sel),
        .status    (status),
        .active    (active),
        .scan_en   (scan_en),
        .restart   (restart)
    );

    // ROM address is the selected bank above the walking offset.
    assign rom_addr = {bank_sel, idx};

    // Shadow copy writes each ROM byte to the same RAM offset.
    assign ram_we    = (phase == PH_SHADOW);
    assign ram_addr  = idx;
    assign ram_wdata = rom_data;

    // Release only in the run phase; expose the sticky status.
    assign cpu_rst_n   = (phase == PH_RUN);
    assign boot_status = status;

endmodule

// File: rtl/bootver_sva.sv
// Checker: temporal rules on the verifier's ports, bound to the top module.
module bootver_sva #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW:0]   rom_addr,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          cpu_rst_n,
    input logic          bank_sel,
    input logic [2:0]    boot_status
);

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |=> bank_sel);

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_status & ~$past(boot_status)) == 3'b000 || !$past(rst_n) || (($past(boot_status) & ~boot_status) == 3'b000));

    // R9
    status_noclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(boot_status) & ~boot_status) != 3'b000)) == 1'b0);

    // R10
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |=> cpu_rst_n);

    // R10
    release_vs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |-> !ram_we);

    // R7
    halt_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_status[2] |-> (!cpu_rst_n && !ram_we));

    // R6
    fallback_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_status[1] |-> bank_sel);

    // R8
    copy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == rom_addr[AW-1:0] && rom_addr[AW] == bank_sel));

    // R8
    copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we) && $past(rst_n)) |-> (ram_addr == $past(ram_addr) + 1'b1));

endmodule

bind dual_image_boot_verifier bootver_sva #(.AW(AW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_addr    (rom_addr),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .cpu_rst_n   (cpu_rst_n),
    .bank_sel    (bank_sel),
    .boot_status (boot_status)
);

// File: tb/dual_image_boot_verifier_test.sv
module dual_image_boot_verifier_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          use_crc;
    logic          shadow_en;
    logic [AW:0]   rom_addr;
    logic [7:0]    rom_data;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          cpu_rst_n;
    logic          bank_sel;
    logic [2:0]    boot_status;

    logic [7:0] img [0:1][0:N-1];
    logic [7:0] ram [0:N-1];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_en = 0;

    // behavioural reference state
    int m_phase, m_idx, m_bank;
    logic [2:0] m_stat;
    bit ok0, ok1, m_shadow;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_image_boot_verifier #(.IMG_BYTES(N)) uut (
        .clk(clk), .rst_n(rst_n), .use_crc(use_crc), .shadow_en(shadow_en),
        .rom_addr(rom_addr), .rom_data(rom_data), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_rst_n(cpu_rst_n),
        .bank_sel(bank_sel), .boot_status(boot_status)
    );

    assign rom_data = img[rom_addr[AW]][rom_addr[AW-1:0]];

    always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int b);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < N-4; i++)
            for (int k = 7; k >= 0; k--) begin
                bit fb = c[31] ^ img[b][i][k];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        return c;
    endfunction

    function automatic bit image_ok(input int b, input bit crc);
        int s = 0;
        if (crc) return ref_crc(b) == {img[b][N-4], img[b][N-3], img[b][N-2], img[b][N-1]};
        for (int i = 0; i < N; i++) s += img[b][i];
        return (s % 256) == 0;
    endfunction

    task automatic build(input int b, input bit crc, input int seed, input bit corrupt);
        int s = 0;
        logic [31:0] c;
        for (int i = 0; i < N; i++) img[b][i] = 8'((seed*13 + i*29 + 7) & 255);
        if (crc) begin
            c = ref_crc(b);
            img[b][N-4] = c[31:24]; img[b][N-3] = c[23:16];
            img[b][N-2] = c[15:8];  img[b][N-1] = c[7:0];
        end else begin
            for (int i = 0; i < N-1; i++) s += img[b][i];
            img[b][N-1] = 8'((256 - (s % 256)) % 256);
        end
        if (corrupt) img[b][2] = img[b][2] ^ 8'h5A;
    endtask

    // reference model step at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_bank = 0; m_stat = 3'b000;
        end else if (m_phase <= 2) begin
            if (m_idx == N-1) begin
                m_idx = 0;
                if (m_phase == 0) begin
                    if (ok0) begin m_stat[0] = 1'b1; m_phase = m_shadow ? 2 : 3; end
                    else begin m_bank = 1; m_stat[1] = 1'b1; m_phase = 1; end
                end else if (m_phase == 1) begin
                    if (ok1) m_phase = m_shadow ? 2 : 3;
                    else begin m_stat[2] = 1'b1; m_phase = 4; end
                end else m_phase = 3;
            end else m_idx++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(cpu_rst_n == (m_phase == 3), "R10 cpu_rst_n per cycle", cpu_rst_n, m_phase == 3);
            chk(bank_sel == m_bank[0], "R9 bank_sel per cycle", bank_sel, m_bank);
            chk(boot_status == m_stat, "R9 status per cycle", boot_status, m_stat);
            chk(ram_we == (m_phase == 2), "R8 ram_we per cycle", ram_we, m_phase == 2);
            if (m_phase <= 2)
                chk(rom_addr == {m_bank[0], AW'(m_idx)}, "R2 rom_addr per cycle", rom_addr, {m_bank[0], AW'(m_idx)});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog R5 actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_case(input string tag, input bit crc, input bit sh,
                            input bit exp_halt, input bit exp_bank, input logic [2:0] exp_stat);
        int w = 0;
        @(negedge clk);
        rst_n = 1'b0; cmp_en = 0; use_crc = crc; shadow_en = sh; m_shadow = sh;
        ok0 = image_ok(0, crc); ok1 = image_ok(1, crc);
        for (int i = 0; i < N; i++) ram[i] = 8'hEE;
        repeat (3) @(negedge clk);
        chk(cpu_rst_n == 0 && bank_sel == 0 && ram_we == 0 && boot_status == 0 && rom_addr == 0,
            "R1 reset state", {cpu_rst_n, bank_sel, ram_we, boot_status, rom_addr}, 0);
        cmp_en = 1; rst_n = 1'b1;
        while (!cpu_rst_n && !boot_status[2] && w < 500) begin @(negedge clk); w++; end
        repeat (4) @(negedge clk);
        chk(cpu_rst_n == !exp_halt, {tag, " R5 release"}, cpu_rst_n, !exp_halt);
        chk(bank_sel == exp_bank, {tag, " R6 bank"}, bank_sel, exp_bank);
        chk(boot_status == exp_stat, {tag, " R9 status"}, boot_status, exp_stat);
        if (sh && !exp_halt)
            for (int i = 0; i < N; i++)
                chk(ram[i] == img[exp_bank][i], {tag, " R8 shadow byte"}, ram[i], img[exp_bank][i]);
        if (exp_halt) begin
            repeat (40) @(negedge clk);
            chk(!cpu_rst_n && !ram_we && boot_status[2], {tag, " R7 halt held"}, {cpu_rst_n, ram_we}, 0);
            for (int i = 0; i < N; i++)
                chk(ram[i] == 8'hEE, {tag, " R7 no RAM write"}, ram[i], 8'hEE);
        end
        cmp_en = 0;
    endtask

    initial begin
        rst_n = 1'b0; use_crc = 1'b0; shadow_en = 1'b0; m_shadow = 0;
        // R3 additive check, primary good, no copy (R5)
        build(0, 0, 1, 0); build(1, 0, 2, 0);
        run_case("R3 sum-pri", 0, 0, 0, 0, 3'b001);
        // R3/R6 primary corrupted, secondary good, shadow (R8)
        build(0, 0, 3, 1); build(1, 0, 4, 0);
        run_case("R3 sum-fallback", 0, 1, 0, 1, 3'b010);
        // R7 both bad
        build(0, 0, 5, 1); build(1, 0, 6, 1);
        run_case("R7 sum-halt", 0, 0, 1, 1, 3'b110);
        // R4 CRC primary good, shadow
        build(0, 1, 7, 0); build(1, 1, 8, 0);
        run_case("R4 crc-pri", 1, 1, 0, 0, 3'b001);
        // R4 sum-valid image must fail CRC method
        build(0, 0, 9, 0); build(1, 1, 10, 0);
        run_case("R4 crc-fallback", 1, 0, 0, 1, 3'b010);
        // R4 both bad under CRC
        build(0, 1, 11, 1); build(1, 1, 12, 1);
        run_case("R4 crc-halt", 1, 1, 1, 1, 3'b110);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule